// File: doc/BRIEF.md
# LPC Bus Interface Power-Down Sequencer

This block sequences the bus interface of a low-pin-count peripheral into and out of its low-power state. The host signals an impending power loss on an active-low power-down request. The block synchronizes that request, holds the bus interface logic in a local reset for as long as it stays asserted, and parks the active-low DMA request pin. Depending on a configuration input, the pin is either driven low or released to high impedance. When the request goes away, the DMA request pin returns to its idle high level first. The local reset is released a fixed number of clocks later, so the interface comes back cleanly even when no platform reset follows, as on a light sleep exit.

The power-down request acts only as a local power-good for the bus interface. Nothing else in the chip is reset by it. An active-low platform reset also forces the local reset and the idle pin drive. A status output reports when the interface is held in its low-power reset.

Top module: `lpc_pd_seq`

## Requirements
- R1: While `plat_rst_n` is low, `bus_rst` is 1, `dmareq_o` is 1, `dmareq_oe` is 1 and `lp_hold` is 0, whatever `pd_req_n` does.
- R2: When `pd_req_n` goes low and stays low, `bus_rst` and `lp_hold` become 1 after the third rising clock edge that samples it low, and not earlier (two synchronizer flops, then the state register).
- R3: While held in power-down with `dma_float` at 0, the DMA request pin is driven low: `dmareq_oe` is 1 and `dmareq_o` is 0.
- R4: While held in power-down with `dma_float` at 1, the pin is released: `dmareq_oe` is 0.
- R5: When `pd_req_n` returns high, then after the third rising edge that samples it high, `dmareq_o` and `dmareq_oe` are 1 and `lp_hold` is 0, while `bus_rst` is still 1.
- R6: `bus_rst` falls exactly `EXIT_CYCLES` rising edges (default 2) after the edge in R5. It never falls directly out of the power-down hold.
- R7: After power-down asserts and deasserts with `plat_rst_n` held high throughout, the block returns to normal operation: `bus_rst` 0, pin driven high, `lp_hold` 0.
- R8: If `pd_req_n` goes low again before the release wait of R6 ends, the block returns to the power-down hold and `bus_rst` stays 1 the whole time.
- R9: After `plat_rst_n` rises, `bus_rst` stays 1 for `EXIT_CYCLES` edges. It then falls if power-down is inactive. If power-down is still requested, the block enters the power-down hold on the first edge instead.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| plat_rst_n | input | 1 | Platform reset, active low, sampled synchronously |
| pd_req_n | input | 1 | Power-down request, active low, asynchronous to clk |
| dma_float | input | 1 | Park choice for the DMA request pin in power-down: 0 drive low, 1 high impedance |
| bus_rst | output | 1 | Local reset for the bus interface logic, active high |
| dmareq_o | output | 1 | Output value for the active-low DMA request pin |
| dmareq_oe | output | 1 | Output enable for the DMA request pin |
| lp_hold | output | 1 | Status: interface held in low-power reset |

## Verification
The bench moves the power-down request through a full entry and exit with the pin parked low, and again with the pin released. These two passes tell the two park modes apart, and they also tell the early pin restore from the later reset release. A request pulse that drops again during the release wait shows whether the sequencer can leak a reset release between two power-down periods. A platform reset applied during power-down, then lifted with the request still active and later with it inactive, separates the forced idle drive from the normal re-entry and release paths. Every check is scheduled at the edge count derived from the two synchronizer stages and the release wait, so an extra or missing register stage is visible.

// File: rtl/lpc_pd_pkg.sv
package lpc_pd_pkg;

    typedef enum logic [1:0] {
        PD_RUN  = 2'd0,
        PD_DOWN = 2'd1,
        PD_EXIT = 2'd2
    } pd_state_e;

    typedef struct packed {
        logic bus_rst;
        logic dq_val;
        logic dq_oe;
        logic hold;
    } pd_pins_t;

    localparam pd_pins_t PINS_IDLE_RESET = '{bus_rst: 1'b1, dq_val: 1'b1, dq_oe: 1'b1, hold: 1'b0};

    function automatic pd_pins_t pins_for(pd_state_e st, logic float_sel);
        pd_pins_t p;
        case (st)
            PD_RUN:  p = '{bus_rst: 1'b0, dq_val: 1'b1, dq_oe: 1'b1, hold: 1'b0};
            PD_DOWN: p = '{bus_rst: 1'b1, dq_val: 1'b0, dq_oe: ~float_sel, hold: 1'b1};
            default: p = PINS_IDLE_RESET;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/lpc_pd_sync.sv
module lpc_pd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic async_n,
    output logic pd_act
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        chain_q[0] <= async_n;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    endgenerate

    assign pd_act = ~chain_q[STAGES-1];
endmodule

// File: rtl/lpc_pd_fsm.sv
module lpc_pd_fsm
    import lpc_pd_pkg::*;
#(
    parameter int EXIT_CYCLES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pd_act,
    output pd_state_e state
);
    localparam int CNT_W = (EXIT_CYCLES > 1) ? $clog2(EXIT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(EXIT_CYCLES - 1);

    pd_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        case (state_q)
            PD_RUN: begin
                if (pd_act) state_d = PD_DOWN;
            end
            PD_DOWN: begin
                if (!pd_act) begin
                    state_d = PD_EXIT;
                    cnt_d   = '0;
                end
            end
            PD_EXIT: begin
                if (pd_act) begin
                    state_d = PD_DOWN;
                end else if (cnt_q == CNT_LAST) begin
                    state_d = PD_RUN;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = PD_EXIT;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PD_EXIT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign state = state_q;

    // R2: a synchronized request in normal operation enters the hold on the next edge
    a_r2_enter_down: assert property (@(posedge clk) disable iff (rst)
        (pd_act && state_q == PD_RUN) |=> (state_q == PD_DOWN));

    // R6: normal operation is only ever reached through the release wait
    a_r6_run_via_exit: assert property (@(posedge clk) disable iff (rst)
        (state_q == PD_RUN && $past(state_q) != PD_RUN) |-> ($past(state_q) == PD_EXIT));

    // R8: a request seen during the release wait goes back to the hold
    a_r8_exit_abort: assert property (@(posedge clk) disable iff (rst)
        (pd_act && state_q == PD_EXIT) |=> (state_q == PD_DOWN));

    // R9: platform reset parks the sequencer in the release wait
    a_r9_reset_to_exit: assert property (@(posedge clk)
        rst |=> (state_q == PD_EXIT));
endmodule

// File: rtl/lpc_pd_outdec.sv
module lpc_pd_outdec
    import lpc_pd_pkg::*;
(
    input  pd_state_e state,
    input  logic      rst,
    input  logic      float_sel,
    output pd_pins_t  pins
);
    always_comb begin
        if (rst) pins = PINS_IDLE_RESET;
        else     pins = pins_for(state, float_sel);
    end
endmodule

// File: rtl/lpc_pd_seq.sv
module lpc_pd_seq
    import lpc_pd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int EXIT_CYCLES = 2
) (
    input  logic clk,
    input  logic plat_rst_n,
    input  logic pd_req_n,
    input  logic dma_float,
    output logic bus_rst,
    output logic dmareq_o,
    output logic dmareq_oe,
    output logic lp_hold
);
    logic      rst;
    logic      pd_act;
    pd_state_e state;
    pd_pins_t  pins;

    assign rst = ~plat_rst_n;

    lpc_pd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .async_n (pd_req_n),
        .pd_act  (pd_act)
    );

    lpc_pd_fsm #(.EXIT_CYCLES(EXIT_CYCLES)) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .pd_act (pd_act),
        .state  (state)
    );

    lpc_pd_outdec u_dec (
        .state     (state),
        .rst       (rst),
        .float_sel (dma_float),
        .pins      (pins)
    );

    assign bus_rst   = pins.bus_rst;
    assign dmareq_o  = pins.dq_val;
    assign dmareq_oe = pins.dq_oe;
    assign lp_hold   = pins.hold;

    // R2: the status never reports a hold without the local reset
    a_r2_hold_has_reset: assert property (@(posedge clk) disable iff (rst)
        lp_hold |-> bus_rst);

    // R5: outside the hold the DMA request pin sits at its driven-high idle
    a_r5_idle_high: assert property (@(posedge clk) disable iff (rst)
        !lp_hold |-> (dmareq_o && dmareq_oe));

    // R4: with the release choice, the pin is not driven during the hold
    a_r4_float_release: assert property (@(posedge clk) disable iff (rst)
        (lp_hold && dma_float) |-> !dmareq_oe);

    // R3: with the drive-low choice, the pin is driven low during the hold
    a_r3_drive_low: assert property (@(posedge clk) disable iff (rst)
        (lp_hold && !dma_float) |-> (dmareq_oe && !dmareq_o));
endmodule

// File: tb/tb_lpc_pd_seq.sv
module tb_lpc_pd_seq;
    localparam int CLK_PERIOD = 10;
    localparam int EXIT_CY    = 2;
    localparam int WATCHDOG   = 5000;

    typedef struct {
        int          cyc;
        logic [3:0]  exp;   // {bus_rst, dmareq_o, dmareq_oe, lp_hold}
        string       tag;
    } item_t;

    logic clk = 1'b0;
    logic plat_rst_n = 1'b0;
    logic pd_req_n = 1'b1;
    logic dma_float = 1'b0;
    logic bus_rst, dmareq_o, dmareq_oe, lp_hold;

    int    cnt = 0;
    int    checks = 0;
    int    errors = 0;
    item_t q[$];
    bit    done = 1'b0;

    localparam logic [3:0] E_RUN   = 4'b0110;
    localparam logic [3:0] E_IDLE  = 4'b1110;
    localparam logic [3:0] E_DLOW  = 4'b1011;
    localparam logic [3:0] E_DFLT  = 4'b1001;

    lpc_pd_seq #(.SYNC_STAGES(2), .EXIT_CYCLES(EXIT_CY)) dut (
        .clk        (clk),
        .plat_rst_n (plat_rst_n),
        .pd_req_n   (pd_req_n),
        .dma_float  (dma_float),
        .bus_rst    (bus_rst),
        .dmareq_o   (dmareq_o),
        .dmareq_oe  (dmareq_oe),
        .lp_hold    (lp_hold)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cnt <= cnt + 1;

    task automatic expect_in(int dly, logic [3:0] e, string tag);
        item_t it;
        it.cyc = cnt + dly;
        it.exp = e;
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic edges(int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: samples a quarter period after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            while (q.size() > 0 && q[0].cyc <= cnt) begin
                item_t it;
                logic [3:0] act;
                it = q.pop_front();
                act = {bus_rst, dmareq_o, dmareq_oe, lp_hold};
                checks++;
                if (it.cyc != cnt || act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: cycle %0d actual=%b expected=%b", it.tag, cnt, act, it.exp);
                end
            end
        end
    end

    // driver
    initial begin
        edges(3);
        expect_in(1, E_IDLE, "R1 reset idle");
        pd_req_n = 1'b0;                     // request ignored while in platform reset
        edges(4);
        expect_in(1, E_IDLE, "R1 reset ignores request");
        pd_req_n = 1'b1;
        edges(4);

        // R9 release with power-down inactive
        plat_rst_n = 1'b1;
        expect_in(1, E_IDLE, "R9 reset held after release");
        expect_in(EXIT_CY, E_RUN, "R9 reset released");
        edges(5);

        // R2/R3 entry with drive-low park
        dma_float = 1'b0;
        pd_req_n = 1'b0;
        expect_in(2, E_RUN, "R2 not yet in hold");
        expect_in(3, E_DLOW, "R2 R3 hold drive low");
        edges(6);

        // R5/R6/R7 exit without platform reset
        pd_req_n = 1'b1;
        expect_in(2, E_DLOW, "R5 still held");
        expect_in(3, E_IDLE, "R5 pin high before reset release");
        expect_in(3 + EXIT_CY - 1, E_IDLE, "R6 reset still held");
        expect_in(3 + EXIT_CY, E_RUN, "R6 R7 recovered");
        edges(8);

        // R4 release park
        dma_float = 1'b1;
        pd_req_n = 1'b0;
        expect_in(3, E_DFLT, "R4 hold pin released");
        edges(5);
        dma_float = 1'b0;
        expect_in(1, E_DLOW, "R3 park follows config");
        edges(2);
        dma_float = 1'b1;
        edges(2);

        // R8 short deassertion during release wait
        pd_req_n = 1'b1;
        edges(1);
        pd_req_n = 1'b0;
        expect_in(2, E_IDLE, "R8 release wait entered");
        expect_in(3, E_DFLT, "R8 back to hold");
        expect_in(6, E_DFLT, "R8 reset never released");
        edges(8);

        // R1/R9 platform reset during hold, released with request active
        plat_rst_n = 1'b0;
        expect_in(1, E_IDLE, "R1 reset overrides hold");
        edges(3);
        plat_rst_n = 1'b1;
        expect_in(1, E_DFLT, "R9 back to hold after reset");
        edges(4);

        // final exit
        dma_float = 1'b0;
        pd_req_n = 1'b1;
        expect_in(3 + EXIT_CY, E_RUN, "R7 final recovery");
        edges(3 + EXIT_CY + 3);
        done = 1'b1;
    end

    initial begin
        int w;
        for (w = 0; w < WATCHDOG && !(done && q.size() == 0); w++) @(posedge clk);
        if (!(done && q.size() == 0)) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule